// File: doc/BRIEF.md
# SD SPI-Mode Command Issuer

This block sends one command to a memory card that runs in SPI mode and gathers the card's one-byte status reply. A controller presents a 6-bit command index and a 32-bit argument and pulses a start strobe. The block then drives an external byte-wide SPI shifter through a simple exchange handshake: it offers a byte with a one-cycle start pulse and waits for a done pulse that returns the byte shifted in.

The outgoing frame has seven bytes. The first is an all-ones filler. The second is the command byte. The next four carry the argument. The last is a checksum byte that the block computes itself. After the frame the block sends all-ones bytes to poll for a reply, at most eight times. The first poll byte is always thrown away. A later byte is taken as the reply once its top bit is clear. The block classifies the reply as no card present, a command checksum error, some other error, or success, and ends the command with a one-cycle done pulse.

Top module: `sdc_cmd_issuer`

## Requirements
- R1: Frame byte 0 is 0xFF and frame byte 1 is 0x40 OR the 6-bit command index, so bit 7 is 0 and bit 6 is 1; each byte offered with `xfer_start` holds on `xfer_tx` until the exchange completes.
- R2: Frame bytes 2 to 5 carry the 32-bit argument, most significant byte first.
- R3: Frame byte 6 is the CRC7 (polynomial x^7+x^3+1, initial value zero) of frame bytes 1 to 5, placed in bits 7:1, with bit 0 set to 1 (for example 0x95 for index 0 with argument 0, and 0x87 for index 8 with argument 0x000001AA).
- R4: After the frame, every poll exchange sends 0xFF, and a command makes at most 8 polls.
- R5: The byte from the first poll is never accepted. A later poll byte with bit 7 equal to 0 ends polling, and that byte becomes `r1_byte`. If no byte is accepted, `r1_byte` is the byte from the eighth poll.
- R6: `err_nocard` is 1 exactly when `r1_byte` is 0xFF.
- R7: `err_crc` is 1 when `r1_byte` is not 0xFF and bit 3 is set.
- R8: `err_other` is 1 when `r1_byte` is not 0xFF, bit 3 is clear and any of bits 7:1 is set. The values 0x00 and 0x01 raise no flag.
- R9: `busy` rises the cycle after an accepted start and stays high until the cycle after the one-cycle `done` pulse. A start strobe while busy has no effect on the frame and starts no new command.
- R10: After reset `busy`, `done`, `xfer_start`, `r1_byte` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_go | input | 1 | Start strobe, taken only while idle |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| r1_byte | output | 8 | Captured status reply |
| err_nocard | output | 1 | No card answered |
| err_crc | output | 1 | Card reported a command checksum error |
| err_other | output | 1 | Card reported another error |
| xfer_tx | output | 8 | Byte offered to the SPI shifter |
| xfer_start | output | 1 | One-cycle request to exchange `xfer_tx` |
| xfer_done | input | 1 | Shifter finished an exchange |
| xfer_rx | input | 8 | Byte the shifter received, valid with `xfer_done` |

## Verification
`busy` is due one cycle after the start strobe is registered, and the bench samples it at the next falling edge. Each exchange request appears in the cycle after the previous `xfer_done`, so the shifter model logs `xfer_tx` at the falling edge where it first sees `xfer_start`. `done` comes one cycle after the last poll's `xfer_done`, and `r1_byte` and the three flags are already stable in that cycle. The bench therefore polls for `done` at falling edges and reads the results in that same cycle. It then checks that `done` and `busy` are low one cycle later.

// File: rtl/sdc_pkg.sv
// Package: shared constants and types for the SD SPI-mode command issuer.
// Assumes byte-wide transfers to the shifter.
package sdc_pkg;
    localparam int BYTE_W   = 8;
    localparam int CRC_W    = 7;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } sdc_state_e;

    // Reply classification
    typedef struct packed {
        logic nocard;
        logic crc;
        logic other;
    } sdc_verdict_t;
endpackage

// File: rtl/sdc_crc7.sv
// Module: sdc_crc7
// Accumulates CRC7 (x^7+x^3+1, zero seed) over whole bytes. Each byte is
// folded in bit-serially, MSB first, in one cycle when feed is high.
// Assumes clear and feed are never high in the same cycle.
module sdc_crc7
    import sdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              feed,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc
);
    localparam logic [CRC_W-1:0] POLY = 7'h09;

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_step;

    // Fold one byte, MSB first, into the running remainder
    always_comb begin
        crc_step = crc_q;
        for (int b = BYTE_W - 1; b >= 0; b--) begin
            if (crc_step[CRC_W-1] ^ din[b])
                crc_step = {crc_step[CRC_W-2:0], 1'b0} ^ POLY;
            else
                crc_step = {crc_step[CRC_W-2:0], 1'b0};
        end
    end

    // Remainder register: cleared per command, updated per fed byte
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            crc_q <= '0;
        else if (feed)
            crc_q <= crc_step;
    end

    assign crc = crc_q;

    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (crc == '0));
endmodule

// File: rtl/sdc_frame_mux.sv
// Module: sdc_frame_mux
// Selects the command frame byte for a given position: filler, command
// byte, argument bytes MSB first, then the CRC byte. Purely combinational.
// Assumes sel stays within 0 .. ARG_W/8+2.
module sdc_frame_mux
    import sdc_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int ARG_W = 32,
    parameter int SEL_W = 3
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ARG_W-1:0]  arg,
    input  logic [CRC_W-1:0]  crc,
    output logic [BYTE_W-1:0] frame_byte
);
    localparam int ARG_BYTES = ARG_W / BYTE_W;

    logic [BYTE_W-1:0] arg_bytes [ARG_BYTES];
    logic [BYTE_W-1:0] cmd_byte;

    // Split the argument into bytes, most significant first
    for (genvar g = 0; g < ARG_BYTES; g++) begin : g_argb
        assign arg_bytes[g] = arg[ARG_W-1-BYTE_W*g -: BYTE_W];
    end

    // Command byte: start bit 0, transmit bit 1, then the index
    always_comb begin
        cmd_byte = '0;
        cmd_byte[BYTE_W-2] = 1'b1;
        cmd_byte[IDX_W-1:0] = idx;
    end

    // Position decode
    always_comb begin
        frame_byte = {crc, 1'b1};
        if (sel == '0)
            frame_byte = IDLE_BYTE;
        else if (sel == SEL_W'(1))
            frame_byte = cmd_byte;
        else begin
            for (int g = 0; g < ARG_BYTES; g++)
                if (int'(sel) == g + 2)
                    frame_byte = arg_bytes[g];
        end
    end
endmodule

// File: rtl/sdc_r1_judge.sv
// Module: sdc_r1_judge
// Classifies a captured status byte into no-card, CRC error, other error.
// The flags are mutually exclusive. Combinational.
module sdc_r1_judge
    import sdc_pkg::*;
(
    input  logic [BYTE_W-1:0] r1,
    output sdc_verdict_t      verdict
);
    localparam int CRC_BIT = 3;

    // Priority: no card, then CRC error, then any non-idle bit
    always_comb begin
        verdict.nocard = (r1 == IDLE_BYTE);
        verdict.crc    = !verdict.nocard && r1[CRC_BIT];
        verdict.other  = !verdict.nocard && !r1[CRC_BIT] && (|r1[BYTE_W-1:1]);
    end
endmodule

// File: rtl/sdc_cmd_issuer.sv
// Module: sdc_cmd_issuer (top)
// Sends one framed command through a byte-exchange shifter, then polls
// for the status reply and classifies it. Assumes the shifter answers each
// xfer_start with exactly one xfer_done, at least one cycle later.
module sdc_cmd_issuer
    import sdc_pkg::*;
#(
    parameter int IDX_W      = 6,
    parameter int ARG_W      = 32,
    parameter int POLL_LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_go,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [ARG_W-1:0]  cmd_arg,
    output logic              busy,
    output logic              done,
    output logic [7:0]        r1_byte,
    output logic              err_nocard,
    output logic              err_crc,
    output logic              err_other,
    output logic [7:0]        xfer_tx,
    output logic              xfer_start,
    input  logic              xfer_done,
    input  logic [7:0]        xfer_rx
);
    localparam int ARG_BYTES = ARG_W / BYTE_W;
    localparam int FRAME_LEN = ARG_BYTES + 3;
    localparam int SEL_W     = $clog2(FRAME_LEN);
    localparam int PCNT_W    = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
    localparam logic [SEL_W-1:0]  LAST_SEL  = SEL_W'(FRAME_LEN - 1);
    localparam logic [PCNT_W-1:0] LAST_POLL = PCNT_W'(POLL_LIMIT - 1);

    sdc_state_e        state_q;
    logic [SEL_W-1:0]  sel_q;
    logic [PCNT_W-1:0] poll_q;
    logic              in_poll_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ARG_W-1:0]  arg_q;
    logic [7:0]        r1_q;
    logic [CRC_W-1:0]  crc_val;
    logic [7:0]        frame_byte;
    logic              crc_feed;
    logic              crc_clear;
    logic              accept_go;
    logic              reply_ok;
    sdc_verdict_t      verdict;

    assign accept_go = (state_q == ST_IDLE) && cmd_go;
    assign crc_clear = accept_go;
    // Feed command and argument bytes as they are offered
    assign crc_feed  = (state_q == ST_ISSUE) && !in_poll_q &&
                       (sel_q != '0) && (sel_q != LAST_SEL);
    // Reply qualifies after the first poll when bit 7 is clear
    assign reply_ok  = (poll_q != '0) && !xfer_rx[7];

    sdc_crc7 i_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (crc_clear),
        .feed  (crc_feed),
        .din   (frame_byte),
        .crc   (crc_val)
    );

    sdc_frame_mux #(
        .IDX_W (IDX_W),
        .ARG_W (ARG_W),
        .SEL_W (SEL_W)
    ) i_mux (
        .sel        (sel_q),
        .idx        (idx_q),
        .arg        (arg_q),
        .crc        (crc_val),
        .frame_byte (frame_byte)
    );

    sdc_r1_judge i_judge (
        .r1      (r1_q),
        .verdict (verdict)
    );

    // Sequencer: frame bytes, then polls, then a done cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            sel_q     <= '0;
            poll_q    <= '0;
            in_poll_q <= 1'b0;
            idx_q     <= '0;
            arg_q     <= '0;
            r1_q      <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cmd_go) begin
                        idx_q     <= cmd_idx;
                        arg_q     <= cmd_arg;
                        sel_q     <= '0;
                        poll_q    <= '0;
                        in_poll_q <= 1'b0;
                        state_q   <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (xfer_done) begin
                        if (!in_poll_q) begin
                            if (sel_q == LAST_SEL)
                                in_poll_q <= 1'b1;
                            else
                                sel_q <= sel_q + 1'b1;
                            state_q <= ST_ISSUE;
                        end else if (reply_ok || poll_q == LAST_POLL) begin
                            r1_q    <= xfer_rx;
                            state_q <= ST_DONE;
                        end else begin
                            poll_q  <= poll_q + 1'b1;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output drive
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_DONE);
        xfer_start = (state_q == ST_ISSUE);
        xfer_tx    = in_poll_q ? IDLE_BYTE : frame_byte;
        r1_byte    = r1_q;
        err_nocard = verdict.nocard;
        err_crc    = verdict.crc;
        err_other  = verdict.other;
    end

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
    p_busy_needs_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    p_go_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && !busy) |=> busy);
    p_start_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> !xfer_start);
    p_tx_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> $stable(xfer_tx));
    p_nocard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_nocard) |-> (r1_byte == 8'hFF));
    p_crc_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_crc) |-> (r1_byte[3] && !err_other));
endmodule

// File: tb/test_sdc_cmd_issuer.sv
module test_sdc_cmd_issuer;
    localparam int CLK_PERIOD = 10;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_go = 1'b0;
    logic [5:0]  cmd_idx = '0;
    logic [31:0] cmd_arg = '0;
    logic        busy, done, err_nocard, err_crc, err_other, xfer_start;
    logic [7:0]  r1_byte, xfer_tx;
    logic        xfer_done = 1'b0;
    logic [7:0]  xfer_rx = '0;

    int total = 0;
    int bad = 0;

    logic [7:0] tx_log [0:1023];
    int         tx_n = 0;
    int         base = 0;
    int         lat_cnt = 0;
    logic [7:0] pending = '0;
    logic [7:0] replies [0:7];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdc_cmd_issuer i_sdc_cmd_issuer (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_idx(cmd_idx),
        .cmd_arg(cmd_arg), .busy(busy), .done(done), .r1_byte(r1_byte),
        .err_nocard(err_nocard), .err_crc(err_crc), .err_other(err_other),
        .xfer_tx(xfer_tx), .xfer_start(xfer_start), .xfer_done(xfer_done),
        .xfer_rx(xfer_rx)
    );

    // Shifter model: logs offered bytes, answers after a fixed latency
    always @(negedge clk) begin
        xfer_done <= 1'b0;
        if (lat_cnt > 0) begin
            lat_cnt <= lat_cnt - 1;
            if (lat_cnt == 1) begin
                xfer_done <= 1'b1;
                xfer_rx   <= pending;
            end
        end else if (xfer_start) begin
            tx_log[tx_n] <= xfer_tx;
            if (tx_n - base >= 7 && tx_n - base < 15)
                pending <= replies[tx_n - base - 7];
            else
                pending <= 8'hFF;
            tx_n    <= tx_n + 1;
            lat_cnt <= LAT;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc7(logic [39:0] bytes);
        logic [6:0] c = '0;
        for (int i = 39; i >= 0; i--) begin
            logic fb = c[6] ^ bytes[i];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    // Issue one command and check frame, polls, result and handshake
    task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                           input logic [7:0] rep [0:7], input int known_crc,
                           input bit poke_mid);
        logic [7:0] cmd_b, crc_b, exp_r1;
        int exp_polls, start_n, cyc;
        bit got;
        for (int i = 0; i < 8; i++) replies[i] = rep[i];
        exp_polls = 8;
        exp_r1 = rep[7];
        for (int p = 0; p < 8; p++) begin
            if (p > 0 && !rep[p][7]) begin
                exp_polls = p + 1; exp_r1 = rep[p]; break;
            end
        end
        cmd_b = 8'h40 | {2'b00, idx};
        crc_b = (known_crc >= 0) ? known_crc[7:0]
                                 : {ref_crc7({cmd_b, arg}), 1'b1};
        @(negedge clk);
        base = tx_n; start_n = tx_n;
        cmd_idx = idx; cmd_arg = arg; cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
        check("R9 busy after start", busy, 1);
        got = 0;
        for (cyc = 0; cyc < 600; cyc++) begin
            if (poke_mid && cyc == 5) begin
                cmd_idx = ~idx; cmd_arg = ~arg; cmd_go = 1'b1;
            end else cmd_go = 1'b0;
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
        cmd_go = 1'b0;
        check("R9 done seen", got, 1);
        check("R1 filler byte", tx_log[start_n], 8'hFF);
        check("R1 command byte", tx_log[start_n+1], cmd_b);
        for (int k = 0; k < 4; k++)
            check("R2 argument byte", tx_log[start_n+2+k], arg[31-8*k -: 8]);
        check("R3 crc byte", tx_log[start_n+6], crc_b);
        check("R4 poll count", tx_n - start_n - 7, exp_polls);
        for (int k = 0; k < exp_polls; k++)
            check("R4 poll byte", tx_log[start_n+7+k], 8'hFF);
        check("R5 r1 byte", r1_byte, exp_r1);
        check("R6 nocard flag", err_nocard, exp_r1 == 8'hFF);
        check("R7 crc flag", err_crc, exp_r1 != 8'hFF && exp_r1[3]);
        check("R8 other flag", err_other,
              exp_r1 != 8'hFF && !exp_r1[3] && (|exp_r1[7:1]));
        @(negedge clk);
        check("R9 done one cycle", done, 0);
        check("R9 busy low after done", busy, 0);
        if (poke_mid) begin
            start_n = tx_n;
            repeat (6) @(negedge clk);
            check("R9 ignored start, no new command", busy, 0);
            check("R9 ignored start, no new bytes", tx_n, start_n);
        end
    endtask

    task automatic t_reset();
        check("R10 busy", busy, 0);
        check("R10 done", done, 0);
        check("R10 xfer_start", xfer_start, 0);
        check("R10 r1 byte", r1_byte, 0);
        check("R10 flags", {err_nocard, err_crc, err_other}, 0);
    endtask

    task automatic t_idle_reply();      // R3 known crc, R5 idle success
        logic [7:0] r [0:7] = '{8'hFF, 8'h01, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        run_cmd(6'd0, 32'h0, r, 8'h95, 0);
    endtask

    task automatic t_first_poll_ignored(); // R5: first byte 0x00 skipped
        logic [7:0] r [0:7] = '{8'h00, 8'hFF, 8'h05, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        run_cmd(6'd8, 32'h0000_01AA, r, 8'h87, 0);
    endtask

    task automatic t_no_card();         // R6, R4 eight polls
        logic [7:0] r [0:7] = '{default: 8'hFF};
        run_cmd(6'd17, 32'h1234_5678, r, -1, 0);
    endtask

    task automatic t_crc_error();       // R7
        logic [7:0] r [0:7] = '{8'hFF, 8'hFF, 8'hFF, 8'h09, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        run_cmd(6'd55, 32'hDEAD_BEEF, r, -1, 0);
    endtask

    task automatic t_stuck_high_bit();  // R8: eighth poll byte 0x80 kept
        logic [7:0] r [0:7] = '{default: 8'h80};
        run_cmd(6'd63, 32'h8000_0001, r, -1, 0);
    endtask

    task automatic t_clean_zero();      // R8 success on 0x00
        logic [7:0] r [0:7] = '{8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        run_cmd(6'd41, 32'h4000_0000, r, -1, 0);
    endtask

    task automatic t_start_while_busy(); // R9
        logic [7:0] r [0:7] = '{8'hFF, 8'hFF, 8'h01, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
        run_cmd(6'd13, 32'h0F0F_A5A5, r, -1, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_reply();
        t_first_poll_ignored();
        t_no_card();
        t_crc_error();
        t_stuck_high_bit();
        t_clean_zero();
        t_start_while_busy();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule